// File: doc/BRIEF.md
# Overclock Watchdog With Safe Fallback

This block supervises a programmable clock frequency setting. Software arms it with an enable bit, an 8-bit timeout in coarse units and a 5-bit safe frequency code. An externally supplied prescale tick marks each timeout unit, nominally 290 ms. Every completed serial write reloads the count. If the count runs out, the block latches an alarm status bit, presents the safe code as an override for the frequency selection, and drives a fixed-length active-low system reset.

The same reset pulse is issued when the frequency ratio changes. The alarm, and with it the override, stays in force until software clears it. While the watchdog is disabled or in alarm, the counter tracks the programmed timeout. Counting therefore starts from the full value whenever the watchdog resumes.

Top module: `freq_watchdog`

## Requirements
- R1: After reset, alarmStatus is 0, overrideValid is 0, overrideCode is 0 and sysRstN is 1.
- R2: Once enabled with timeout N (N >= 1), alarmStatus stays 0 through the first N-1 accepted ticks and becomes 1 in the cycle after the N-th tick. A timeout of 0 alarms on the first tick.
- R3: On expiry, overrideValid becomes 1 and overrideCode takes the value safeCode had in the expiry cycle. Later changes to safeCode do not alter overrideCode while the alarm holds.
- R4: Expiry drives sysRstN low for exactly 16 clock cycles, starting in the cycle after the expiring tick.
- R5: A ratioChg strobe drives sysRstN low for 16 cycles starting in the next cycle, without setting the alarm. A new strobe during a pulse restarts the 16-cycle length.
- R6: A restartStb pulse reloads the counter, so N further ticks are needed before expiry.
- R7: While wdEnable is 0, ticks have no effect: there is no alarm and no reset pulse.
- R8: alarmStatus stays 1 until an alarmClr strobe. The strobe clears alarmStatus and overrideValid in the next cycle, and counting restarts from the full timeout.
- R9: Ticks during an alarm cause no further reset pulse and do not clear the alarm.
- R10: A change of timeoutCount while counting takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle prescale tick, one per timeout unit |
| wdEnable | input | 1 | Watchdog enable (1 = armed) |
| timeoutCount | input | 8 | Timeout in tick units |
| safeCode | input | 5 | Safe frequency code: extension bit (bit 4) and four select bits |
| restartStb | input | 1 | Reload strobe, one per completed serial write |
| alarmClr | input | 1 | Software write of 0 to the alarm status bit |
| ratioChg | input | 1 | Strobe marking a frequency ratio change |
| alarmStatus | output | 1 | 1 = alarm, 0 = normal |
| overrideCode | output | 5 | Safe code that replaces the active selection |
| overrideValid | output | 1 | overrideCode is in force |
| sysRstN | output | 1 | Active-low system reset pulse |

## Verification
The assertions assume that every strobe input (tickIn, restartStb, alarmClr, ratioChg) lasts a single clock cycle. They also assume that alarmClr is only issued when a write is meant to drop the alarm. The bench drives each strobe for one cycle at a falling edge and keeps ticks at least one idle cycle apart. It never asserts restartStb or alarmClr in the same cycle as a tick, so the assertions on alarm stickiness and override stability watch only the orderings the block is meant to see.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ALARM = 2'd2
  } fwdState_t;

  typedef struct packed {
    logic reload;
    logic decrement;
    logic expire;
    logic clearAlarm;
    logic ratioPulse;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wdEnable,
  input  logic        tickIn,
  input  logic        restartStb,
  input  logic        alarmClr,
  input  logic        ratioChg,
  input  logic        cntLast,
  output fwdStrobes_t stb
);

  fwdState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb            = '0;
    stb.ratioPulse = ratioChg;
    stateNext      = state;
    unique case (state)
      ST_IDLE: begin
        stb.reload = 1'b1;
        if (wdEnable) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (!wdEnable) begin
          stb.reload = 1'b1;
          stateNext  = ST_IDLE;
        end else if (restartStb) begin
          stb.reload = 1'b1;
        end else if (tickIn) begin
          if (cntLast) begin
            stb.expire = 1'b1;
            stateNext  = ST_ALARM;
          end else begin
            stb.decrement = 1'b1;
          end
        end
      end
      ST_ALARM: begin
        stb.reload = 1'b1;
        if (alarmClr) begin
          stb.clearAlarm = 1'b1;
          stateNext      = wdEnable ? ST_RUN : ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CODE_W     = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwdStrobes_t       stb,
  input  logic [CNT_W-1:0]  timeoutCount,
  input  logic [CODE_W-1:0] safeCode,
  output logic              cntLast,
  output logic              alarmStatus,
  output logic [CODE_W-1:0] overrideCode,
  output logic              overrideValid,
  output logic              sysRstN
);

  localparam int PULSE_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0]   unitsLeft;
  logic [PULSE_W-1:0] pulseLeft;
  logic               pulseTrig;

  always_ff @(posedge clk) begin
    if (!rstN)              unitsLeft <= '0;
    else if (stb.reload)    unitsLeft <= timeoutCount;
    else if (stb.decrement) unitsLeft <= unitsLeft - CNT_W'(1);
  end

  assign cntLast = (unitsLeft <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmStatus   <= 1'b0;
      overrideValid <= 1'b0;
      overrideCode  <= '0;
    end else if (stb.expire) begin
      alarmStatus   <= 1'b1;
      overrideValid <= 1'b1;
      overrideCode  <= safeCode;
    end else if (stb.clearAlarm) begin
      alarmStatus   <= 1'b0;
      overrideValid <= 1'b0;
    end
  end

  assign pulseTrig = stb.expire | stb.ratioPulse;

  always_ff @(posedge clk) begin
    if (!rstN)                 pulseLeft <= '0;
    else if (pulseTrig)        pulseLeft <= PULSE_W'(RST_CYCLES);
    else if (pulseLeft != '0)  pulseLeft <= pulseLeft - PULSE_W'(1);
  end

  assign sysRstN = (pulseLeft == '0);

endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
  import fwd_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CODE_W     = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wdEnable,
  input  logic [CNT_W-1:0]  timeoutCount,
  input  logic [CODE_W-1:0] safeCode,
  input  logic              restartStb,
  input  logic              alarmClr,
  input  logic              ratioChg,
  output logic              alarmStatus,
  output logic [CODE_W-1:0] overrideCode,
  output logic              overrideValid,
  output logic              sysRstN
);

  fwdStrobes_t stb;
  logic        cntLast;

  fwd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wdEnable   (wdEnable),
    .tickIn     (tickIn),
    .restartStb (restartStb),
    .alarmClr   (alarmClr),
    .ratioChg   (ratioChg),
    .cntLast    (cntLast),
    .stb        (stb)
  );

  fwd_datapath #(
    .CNT_W      (CNT_W),
    .CODE_W     (CODE_W),
    .RST_CYCLES (RST_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .timeoutCount  (timeoutCount),
    .safeCode      (safeCode),
    .cntLast       (cntLast),
    .alarmStatus   (alarmStatus),
    .overrideCode  (overrideCode),
    .overrideValid (overrideValid),
    .sysRstN       (sysRstN)
  );

endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wdEnable,
  input logic              alarmClr,
  input logic              ratioChg,
  input logic [CODE_W-1:0] safeCode,
  input logic              alarmStatus,
  input logic [CODE_W-1:0] overrideCode,
  input logic              overrideValid,
  input logic              sysRstN
);

  // R4: a fresh alarm is accompanied by the reset pulse
  a_r4_rst_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmStatus) |-> !sysRstN);

  // R5: a ratio change strobe pulls the reset low next cycle
  a_r5_rst_on_ratio: assert property (@(posedge clk) disable iff (!rstN)
    ratioChg |=> !sysRstN);

  // R3: the override takes the safe code seen at expiry
  a_r3_safe_capture: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrideValid) |-> (overrideCode == $past(safeCode)));

  // R3: the override code does not move while it is in force
  a_r3_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    (overrideValid && $past(overrideValid)) |-> $stable(overrideCode));

  // R8: the alarm is sticky until cleared
  a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (alarmStatus && !alarmClr) |=> alarmStatus);

  // R7: no alarm can arise while disabled
  a_r7_no_alarm_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!wdEnable && !alarmStatus) |=> !alarmStatus);

endmodule

bind freq_watchdog fwd_checker #(.CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wdEnable      (wdEnable),
  .alarmClr      (alarmClr),
  .ratioChg      (ratioChg),
  .safeCode      (safeCode),
  .alarmStatus   (alarmStatus),
  .overrideCode  (overrideCode),
  .overrideValid (overrideValid),
  .sysRstN       (sysRstN)
);

// File: tb/freq_watchdog_tb.sv
module freq_watchdog_tb;

  localparam int RSTC = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wdEnable = 1'b0;
  logic [7:0] timeoutCount = 8'd0;
  logic [4:0] safeCode = 5'd0;
  logic       restartStb = 1'b0;
  logic       alarmClr = 1'b0;
  logic       ratioChg = 1'b0;
  logic       alarmStatus;
  logic [4:0] overrideCode;
  logic       overrideValid;
  logic       sysRstN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  freq_watchdog u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wdEnable(wdEnable),
    .timeoutCount(timeoutCount), .safeCode(safeCode), .restartStb(restartStb),
    .alarmClr(alarmClr), .ratioChg(ratioChg), .alarmStatus(alarmStatus),
    .overrideCode(overrideCode), .overrideValid(overrideValid), .sysRstN(sysRstN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) tickIn = 1'b1;
    @(negedge clk) tickIn = 1'b0;
  endtask

  task automatic pulseRestart();
    @(negedge clk) restartStb = 1'b1;
    @(negedge clk) restartStb = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk) alarmClr = 1'b1;
    @(negedge clk) alarmClr = 1'b0;
  endtask

  task automatic pulseRatio();
    @(negedge clk) ratioChg = 1'b1;
    @(negedge clk) ratioChg = 1'b0;
  endtask

  // called at the first low negedge after a trigger
  task automatic checkPulse(input string tag);
    for (int i = 2; i <= RSTC; i++) begin
      @(negedge clk);
      chk({tag, " rst low"}, sysRstN, 0);
    end
    @(negedge clk);
    chk({tag, " rst released"}, sysRstN, 1);
  endtask

  task automatic settle();
    repeat (RSTC + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog timer expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int sweep [8] = '{0, 1, 2, 3, 4, 7, 16, 255};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 alarm", alarmStatus, 0);
    chk("R1 valid", overrideValid, 0);
    chk("R1 code", overrideCode, 0);
    chk("R1 rst", sysRstN, 1);

    // Sweep of timeout values
    foreach (sweep[k]) begin
      int n = sweep[k];
      int pre = (n == 0) ? 0 : n - 1;
      logic [4:0] sc = 5'((n * 7 + 3) & 31);
      @(negedge clk);
      timeoutCount = 8'(n);
      safeCode = sc;
      wdEnable = 1'b1;
      @(negedge clk);
      for (int t = 0; t < pre; t++) tick();
      chk($sformatf("R2 n=%0d no alarm before last tick", n), alarmStatus, 0);
      chk($sformatf("R2 n=%0d no reset before last tick", n), sysRstN, 1);
      tick();
      chk($sformatf("R2 n=%0d alarm", n), alarmStatus, 1);
      chk($sformatf("R3 n=%0d valid", n), overrideValid, 1);
      chk($sformatf("R3 n=%0d code", n), overrideCode, sc);
      chk($sformatf("R4 n=%0d rst", n), sysRstN, 0);
      checkPulse($sformatf("R4 n=%0d", n));
      safeCode = ~sc;
      tick();
      tick();
      chk($sformatf("R9 n=%0d alarm held", n), alarmStatus, 1);
      chk($sformatf("R9 n=%0d no new reset", n), sysRstN, 1);
      chk($sformatf("R3 n=%0d code kept", n), overrideCode, sc);
      wdEnable = 1'b0;
      pulseClear();
      chk($sformatf("R8 n=%0d alarm cleared", n), alarmStatus, 0);
      chk($sformatf("R8 n=%0d valid cleared", n), overrideValid, 0);
    end

    // R6 restart and R8 recount after clear
    @(negedge clk);
    timeoutCount = 8'd4;
    safeCode = 5'd17;
    wdEnable = 1'b1;
    @(negedge clk);
    repeat (3) tick();
    pulseRestart();
    repeat (3) tick();
    chk("R6 no alarm after restart", alarmStatus, 0);
    tick();
    chk("R6 alarm after full count", alarmStatus, 1);
    settle();
    pulseClear();
    chk("R8 cleared while enabled", alarmStatus, 0);
    repeat (3) tick();
    chk("R8 recount not yet expired", alarmStatus, 0);
    tick();
    chk("R8 recount expired", alarmStatus, 1);
    chk("R3 code 17", overrideCode, 17);
    settle();
    wdEnable = 1'b0;
    pulseClear();

    // R7 disabled
    timeoutCount = 8'd2;
    repeat (6) tick();
    chk("R7 disabled no alarm", alarmStatus, 0);
    chk("R7 disabled no reset", sysRstN, 1);
    wdEnable = 1'b1;
    @(negedge clk);
    tick();
    chk("R7 fresh count after enable", alarmStatus, 0);
    tick();
    chk("R7 expiry after enable", alarmStatus, 1);
    settle();
    wdEnable = 1'b0;
    pulseClear();

    // R10 timeout change mid-count
    timeoutCount = 8'd3;
    wdEnable = 1'b1;
    @(negedge clk);
    tick();
    timeoutCount = 8'd1;
    tick();
    chk("R10 new count not applied", alarmStatus, 0);
    tick();
    chk("R10 old count expires", alarmStatus, 1);
    settle();
    wdEnable = 1'b0;
    pulseClear();

    // R5 ratio change pulses and retrigger
    pulseRatio();
    chk("R5 ratio rst", sysRstN, 0);
    chk("R5 no alarm", alarmStatus, 0);
    checkPulse("R5 single");
    pulseRatio();
    repeat (4) begin
      @(negedge clk);
      chk("R5 first pulse low", sysRstN, 0);
    end
    pulseRatio();
    chk("R5 retrigger low", sysRstN, 0);
    checkPulse("R5 retrigger");
    chk("R5 alarm untouched", alarmStatus, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule